// File: doc/BRIEF.md
# Clock Power-Down Gating Controller

This block sits between a set of free-running generated clocks and the pins that carry them. Each output passes its source clock only while its own enable bit is set and the block is not powered down. An enable that is cleared holds the output actively low. Outputs are never tristated.

A low level on the asynchronous power-down pin is first brought through a two-stage synchronizer clocked by the CPU reference clock. It is acted on only after the synchronized value reads low on two consecutive rising edges. Every gate then drops at the next falling edge of its own source clock, so no output ever emits a short pulse. Each gate's state is synchronized back into the reference domain. Once every gate reads closed, the block raises a request to switch the PLLs off.

When the pin returns high, the PLL-off request drops on the first cycle the synchronized input is high. The outputs stay low for a programmable number of reference cycles while the PLLs relock. They then restart on a rising edge of their source clocks. Reset sets every internal enable to 1 and puts the sequencer in the running state.

Top module: `clkgate_pwrdn`

## Requirements
- R1: While running, `gated_clk[i]` follows `raw_clk[i]` whenever `out_en[i]` is 1. Bit i of `out_en` controls only output i.
- R2: An output whose `out_en` bit is 0 is held at 0 and shows no rising edge.
- R3: A gate opens or closes only while its source clock is low. Every high pulse on `gated_clk[i]` lasts exactly one full high phase of `raw_clk[i]`, including when an enable bit changes at random times.
- R4: A low on `pwrdn_req_n` that the synchronizer presents for only one reference cycle has no effect: `pll_off` stays 0 and enabled outputs keep toggling. A low presented for two consecutive cycles starts power-down.
- R5: After power-down starts, every output goes low at its next source falling edge. Once all gates read closed, `pll_off` rises to 1. While `pll_off` is 1, all outputs are 0.
- R6: `pwrdn_req_n` passes through a two-flop synchronizer. After it returns high, `pll_off` is still 1 after the first reference rising edge and is 0 after the third.
- R7: After `pll_off` falls, all outputs stay low for `LOCK_CYCLES` reference cycles. Enabled outputs then resume, starting with a full high pulse.
- R8: Synchronous reset sets the internal enable vector to all ones and the sequencer to running, with `pll_off` at 0. This holds even when reset arrives during power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU reference clock, the sequencer's clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_req_n | input | 1 | Asynchronous power-down request, active low |
| out_en | input | NUM_OUT | Per-output enable bits, 1 = run |
| raw_clk | input | NUM_OUT | Free-running source clocks to be gated |
| gated_clk | output | NUM_OUT | Gated clock outputs, low when stopped |
| pll_off | output | 1 | Request to shut the PLLs down, active high |

## Verification
A sequencer stuck in the wrong state shows within a few reference cycles in one of two ways. Either `pll_off` is raised while some output still toggles, or outputs come back before the lock wait has run out. Both are visible on edge counts taken over short windows. A gate that updates outside its source's low phase shows as a high pulse shorter than the source's high phase, and pulse widths are measured at every output edge. A lost synchronizer stage or a one-sample detector moves the `pll_off` edges by a cycle, or lets a single-cycle glitch stop the clocks. Either effect appears within the same pulse.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_OFF  = 2'd2,
    ST_LOCK = 2'd3
  } cg_state_e;
endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cg_pd_fsm.sv
`timescale 1ns/1ps
module cg_pd_fsm
  import cg_pkg::*;
#(
  parameter int LOCK_CYCLES = 64,
  parameter int SETTLE      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n_s,
  input  logic all_stopped,
  output logic clk_run,
  output logic pll_off
);
  localparam int CNT_MAX = (LOCK_CYCLES > SETTLE) ? LOCK_CYCLES : SETTLE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  cg_state_e  state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic       pd_n_d;
  logic       low_twice;

  assign low_twice = !pd_n_s && !pd_n_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: begin
        cnt_d = '0;
        if (low_twice) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (pd_n_s) begin
          state_d = ST_LOCK;
          cnt_d   = '0;
        end else if (all_stopped && cnt_q >= CNT_W'(SETTLE)) begin
          state_d = ST_OFF;
        end else if (cnt_q < CNT_W'(SETTLE)) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_OFF: begin
        cnt_d = '0;
        if (pd_n_s) state_d = ST_LOCK;
      end
      ST_LOCK: begin
        if (low_twice) begin
          state_d = ST_STOP;
          cnt_d   = '0;
        end else if (cnt_q == CNT_W'(LOCK_CYCLES - 1)) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      pd_n_d  <= 1'b1;
      clk_run <= 1'b1;
      pll_off <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pd_n_d  <= pd_n_s;
      clk_run <= (state_d == ST_RUN);
      pll_off <= (state_d == ST_OFF);
    end
  end
endmodule

// File: rtl/cg_out_gate.sv
`timescale 1ns/1ps
module cg_out_gate (
  input  logic raw_clk,
  input  logic rst,
  input  logic run,
  output logic gate_q,
  output logic gated
);
  // Sampling on the falling edge keeps the gate stable for the whole high phase
  always_ff @(negedge raw_clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= run;
  end

  assign gated = raw_clk & gate_q;
endmodule

// File: rtl/clkgate_pwrdn.sv
`timescale 1ns/1ps
module clkgate_pwrdn #(
  parameter int NUM_OUT     = 8,
  parameter int LOCK_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwrdn_req_n,
  input  logic [NUM_OUT-1:0] out_en,
  input  logic [NUM_OUT-1:0] raw_clk,
  output logic [NUM_OUT-1:0] gated_clk,
  output logic               pll_off
);
  localparam int SETTLE = SYNC_STAGES + 1;

  logic               pd_n_s;
  logic               clk_run;
  logic [NUM_OUT-1:0] en_q;
  logic [NUM_OUT-1:0] run_q;
  logic [NUM_OUT-1:0] gate_state;
  logic [NUM_OUT-1:0] gate_seen;
  logic               all_stopped;

  cg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst(rst), .d(pwrdn_req_n), .q(pd_n_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '1;
      run_q <= '1;
    end else begin
      en_q  <= out_en;
      run_q <= en_q & {NUM_OUT{clk_run}};
    end
  end

  cg_pd_fsm #(.LOCK_CYCLES(LOCK_CYCLES), .SETTLE(SETTLE)) u_fsm (
    .clk(clk), .rst(rst), .pd_n_s(pd_n_s), .all_stopped(all_stopped),
    .clk_run(clk_run), .pll_off(pll_off)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_gate
    cg_out_gate u_gate (
      .raw_clk(raw_clk[g]), .rst(rst), .run(run_q[g]),
      .gate_q(gate_state[g]), .gated(gated_clk[g])
    );
  end

  cg_sync #(.WIDTH(NUM_OUT), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ack_sync (
    .clk(clk), .rst(rst), .d(gate_state), .q(gate_seen)
  );

  assign all_stopped = ~|gate_seen;
endmodule

// File: rtl/cg_checker.sv
`timescale 1ns/1ps
module cg_checker #(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pll_off,
  input logic               pd_n_s,
  input logic               clk_run,
  input logic [NUM_OUT-1:0] en_q,
  input logic [NUM_OUT-1:0] gated_clk
);
  AST_OFF_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (rst)
    pll_off |-> (gated_clk == '0)); // R5

  AST_RELEASE_DROPS_OFF: assert property (@(posedge clk) disable iff (rst)
    (pll_off && pd_n_s) |=> !pll_off); // R6

  AST_LOCK_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_off) |-> (gated_clk == '0)); // R7

  AST_NEEDS_TWO_LOWS: assert property (@(posedge clk) disable iff (rst)
    (clk_run && pd_n_s) |=> clk_run); // R4

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!pll_off && clk_run && en_q == '1)); // R8
endmodule

bind clkgate_pwrdn cg_checker #(.NUM_OUT(NUM_OUT)) u_cg_checker (
  .clk(clk), .rst(rst), .pll_off(pll_off), .pd_n_s(pd_n_s),
  .clk_run(clk_run), .en_q(en_q), .gated_clk(gated_clk)
);

// File: tb/clkgate_pwrdn_test.sv
`timescale 1ns/1ps
module clkgate_pwrdn_test;
  localparam real CLK_PERIOD = 10.0;
  localparam int  N          = 6;
  localparam int  LOCK       = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pd_n = 1'b1;
  logic [N-1:0] out_en = '1;
  logic [N-1:0] raw;
  logic [N-1:0] gated;
  logic         pll_off;
  logic [N*16-1:0] cnt_bus;
  logic [N-1:0]    runt_flag;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgate_pwrdn #(.NUM_OUT(N), .LOCK_CYCLES(LOCK), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .pwrdn_req_n(pd_n), .out_en(out_en),
    .raw_clk(raw), .gated_clk(gated), .pll_off(pll_off)
  );

  // Source clocks with distinct half periods (4+g ns) and phase offsets
  for (genvar g = 0; g < N; g++) begin : g_src
    logic r = 1'b0;
    logic [15:0] edges = '0;
    logic runt = 1'b0;
    realtime t_rise = 0.0;
    initial begin
      #(0.3 + 0.7 * g);
      forever #(4.0 + g) r = ~r;
    end
    assign raw[g] = r;
    always @(posedge gated[g]) begin
      edges  <= edges + 1'b1;
      t_rise = $realtime;
    end
    // R3: each gated high pulse must span the full source high phase
    always @(negedge gated[g]) begin
      if (($realtime - t_rise) < (4.0 + g) - 0.01 ||
          ($realtime - t_rise) > (4.0 + g) + 0.01) runt <= 1'b1;
    end
    assign cnt_bus[g*16 +: 16] = edges;
    assign runt_flag[g] = runt;
  end

  function automatic logic [N-1:0] exp_mask(input logic [N-1:0] en, input bit running);
    return running ? en : '0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Returns which outputs showed any rising edge over n reference cycles
  task automatic window(input int n, output logic [N-1:0] active);
    logic [N*16-1:0] snap;
    snap = cnt_bus;
    cycles(n);
    for (int k = 0; k < N; k++)
      active[k] = (cnt_bus[k*16 +: 16] != snap[k*16 +: 16]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] act;
    logic [N-1:0] en;
    void'($urandom(32'h5eed_c10c));
    cycles(5);
    rst = 1'b0;
    cycles(1);
    check(pll_off == 1'b0, "R8", pll_off, 0);
    cycles(10);
    window(30, act);
    check(act == exp_mask('1, 1), "R8", act, exp_mask('1, 1));

    // Directed: bit position of the enable vector
    out_en = 6'b000001; cycles(10); window(30, act);
    check(act == 6'b000001, "R1", act, 6'b000001);
    out_en = 6'b100000; cycles(10); window(30, act);
    check(act == 6'b100000, "R2", act, 6'b100000);

    // Directed: a one-cycle low is ignored, a two-cycle low stops the clocks
    out_en = '1; cycles(10);
    pd_n = 1'b0; cycles(1); pd_n = 1'b1;
    cycles(4);
    check(pll_off == 1'b0, "R4", pll_off, 0);
    window(20, act);
    check(act == '1, "R4", act, '1);
    pd_n = 1'b0; cycles(2); pd_n = 1'b1;
    cycles(6);
    window(16, act);
    check(act == '0, "R4", act, 0);
    cycles(LOCK + 10);

    for (int it = 0; it < 10; it++) begin
      int mode;
      en = N'($urandom);
      out_en = en;
      cycles(10);
      window(30, act);
      check(act == exp_mask(en, 1), "R1", act, exp_mask(en, 1));
      mode = int'($urandom % 3);
      if (mode == 0) begin
        pd_n = 1'b0; cycles(1); pd_n = 1'b1;
        cycles(4);
        window(20, act);
        check(act == exp_mask(en, 1) && pll_off == 1'b0, "R4", act, exp_mask(en, 1));
      end else if (mode == 1) begin
        pd_n = 1'b0;
        cycles(15 + int'($urandom % 10));
        check(pll_off == 1'b1, "R5", pll_off, 1);
        window(10, act);
        check(act == '0, "R5", act, 0);
        out_en = N'($urandom);
        pd_n = 1'b1;
        cycles(1);
        check(pll_off == 1'b1, "R6", pll_off, 1);
        cycles(2);
        check(pll_off == 1'b0, "R6", pll_off, 0);
        out_en = en;
        window(LOCK - 6, act);
        check(act == '0, "R7", act, 0);
        cycles(16);
        window(30, act);
        check(act == exp_mask(en, 1), "R7", act, exp_mask(en, 1));
      end else begin
        pd_n = 1'b0; cycles(2); pd_n = 1'b1;
        cycles(6);
        window(16, act);
        check(act == '0, "R4", act, 0);
        cycles(LOCK + 10);
      end
    end

    // Reset while powered down returns straight to running
    out_en = '1; cycles(10);
    pd_n = 1'b0; cycles(25);
    check(pll_off == 1'b1, "R5", pll_off, 1);
    rst = 1'b1; pd_n = 1'b1;
    cycles(1);
    check(pll_off == 1'b0, "R8", pll_off, 0);
    cycles(3);
    rst = 1'b0;
    cycles(8);
    window(20, act);
    check(act == '1, "R8", act, '1);

    check(runt_flag == '0, "R3", runt_flag, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule